// File: doc/BRIEF.md
# Automatic Hibernation Power Controller

This block decides whether a small peripheral device is running or asleep. It watches for activity on the device and counts idle cycles. When nothing has happened for a whole idle window, it moves the device from the active state to the hibernate state. There are only these two states, and automatic hibernation cannot be switched off.

Some sources wake the device as soon as they occur: a bus address match, an enabled GPIO input change, an enabled pen touch, a soft reset or the external reset pin. Other sources keep the device awake for as long as they are asserted: a running PWM, a running ADC, or a pen that is held down while touch sensing is enabled. Each functional sub-block asks for its clock through a request bit. The block grants that clock enable only while the device is active.

All inputs and outputs are plain level control and status signals. There is no data stream and no handshake.

Top module: `pwr_autohib`

## Requirements
- R1: After power-on reset, `hib_o` is 0 (active) and every bit of `sub_clk_en_o` is 0.
- R2: With no activity or hold source present, `hib_o` rises on the (IDLE_CYCLES+1)-th rising clock edge after the last edge at which an activity or hold source was sampled high.
- R3: Any wake or hold source seen while active reloads the idle window in full, so hibernation is delayed.
- R4: While `pwm_run_i` or `adc_run_i` is 1, `hib_o` stays 0 no matter how long it lasts.
- R5: `pen_down_i` wakes the device and holds it awake only while `touch_en_i` is 1. While `touch_en_i` is 0, the pen has no effect.
- R6: A GPIO bit n counts as a wake event only when `gpio_chg_i[n]`, `gpio_irq_en_i[n]` and `gpio_is_in_i[n]` are all 1. A change on a pin whose interrupt is disabled, or on a pin configured as an output, leaves `hib_o` at 1.
- R7: A pulse on `addr_hit_i` while the device hibernates wakes it.
- R8: A pulse on `soft_rst_i` or `ext_rst_i` returns the device to active and starts a full idle window.
- R9: Wake is registered. `hib_o` falls at the first rising edge that samples a qualifying event, so the event is not lost.
- R10: `sub_clk_en_o[k]` equals `sub_clk_req_i[k]` gated by the active state, registered once. It is 0 in every cycle where `hib_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-on reset, asynchronous, active low |
| soft_rst_i | input | 1 | Soft reset pulse |
| ext_rst_i | input | 1 | External reset pin, synchronised, active high |
| addr_hit_i | input | 1 | Pulse when a bus transaction matches the device address |
| pen_down_i | input | 1 | Pen is touching the panel |
| touch_en_i | input | 1 | Touch controller enabled |
| pwm_run_i | input | 1 | PWM is running |
| adc_run_i | input | 1 | ADC is converting |
| gpio_chg_i | input | NUM_GPIO | Per-pin input change event |
| gpio_irq_en_i | input | NUM_GPIO | Per-pin interrupt enable |
| gpio_is_in_i | input | NUM_GPIO | Per-pin direction, 1 = input |
| sub_clk_req_i | input | NUM_SUB | Per-sub-block clock request |
| hib_o | output | 1 | 1 = hibernate, 0 = active |
| sub_clk_en_o | output | NUM_SUB | Per-sub-block clock enable |

## Verification
Every result is registered exactly once. A wake, reset or clock-enable change can be seen just after the rising edge that sampled its cause. Entry into hibernation appears IDLE_CYCLES+1 edges after the last sampled activity. The bench drives its stimulus on falling edges and reads the outputs on later falling edges. It counts those edges exactly, checking that `hib_o` is still 0 after IDLE_CYCLES edges and is 1 after one more edge.

// File: rtl/pwr_autohib_pkg.sv
package pwr_autohib_pkg;
  typedef enum logic {
    PWR_ACTIVE = 1'b0,
    PWR_HIB    = 1'b1
  } pwr_state_e;
endpackage

// File: rtl/pwr_wake_qual.sv
module pwr_wake_qual #(
  parameter int NUM_GPIO = 4
) (
  input  logic                addr_hit_i,
  input  logic                pen_down_i,
  input  logic                touch_en_i,
  input  logic                pwm_run_i,
  input  logic                adc_run_i,
  input  logic                soft_rst_i,
  input  logic                ext_rst_i,
  input  logic [NUM_GPIO-1:0] gpio_chg_i,
  input  logic [NUM_GPIO-1:0] gpio_irq_en_i,
  input  logic [NUM_GPIO-1:0] gpio_is_in_i,
  output logic                wake_o,
  output logic                hold_o,
  output logic                rst_evt_o
);
  logic [NUM_GPIO-1:0] gpio_hit;
  logic                pen_ok;

  for (genvar g = 0; g < NUM_GPIO; g++) begin : g_pin
    assign gpio_hit[g] = gpio_chg_i[g] & gpio_irq_en_i[g] & gpio_is_in_i[g];
  end

  assign pen_ok    = pen_down_i & touch_en_i;
  assign wake_o    = addr_hit_i | (|gpio_hit) | pen_ok;
  assign hold_o    = pwm_run_i | adc_run_i | pen_ok;
  assign rst_evt_o = soft_rst_i | ext_rst_i;
endmodule

// File: rtl/pwr_idle_timer.sv
module pwr_idle_timer #(
  parameter int IDLE_CYCLES = 1650
) (
  input  logic clk,
  input  logic rst_n,
  input  logic reload_i,
  output logic expired_o
);
  localparam int CW = $clog2(IDLE_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(IDLE_CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= LOAD;
    else if (reload_i)       cnt_q <= LOAD;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/pwr_state_fsm.sv
module pwr_state_fsm
  import pwr_autohib_pkg::*;
#(
  parameter int NUM_SUB = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wake_i,
  input  logic               hold_i,
  input  logic               rst_evt_i,
  input  logic               expired_i,
  input  logic [NUM_SUB-1:0] clk_req_i,
  output logic               reload_o,
  output logic               hib_o,
  output logic [NUM_SUB-1:0] clk_en_o
);
  pwr_state_e state_q, state_d;
  logic       busy;

  assign busy = wake_i | hold_i | rst_evt_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PWR_ACTIVE: if (!busy && expired_i) state_d = PWR_HIB;
      PWR_HIB:    if (busy)               state_d = PWR_ACTIVE;
      default:                            state_d = PWR_ACTIVE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= PWR_ACTIVE;
      clk_en_o <= '0;
    end else begin
      state_q  <= state_d;
      clk_en_o <= (state_d == PWR_ACTIVE) ? clk_req_i : '0;
    end
  end

  assign reload_o = busy | (state_q == PWR_HIB);
  assign hib_o    = (state_q == PWR_HIB);
endmodule

// File: rtl/pwr_autohib.sv
module pwr_autohib #(
  parameter int NUM_GPIO    = 4,
  parameter int NUM_SUB     = 4,
  parameter int IDLE_CYCLES = 1650
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                soft_rst_i,
  input  logic                ext_rst_i,
  input  logic                addr_hit_i,
  input  logic                pen_down_i,
  input  logic                touch_en_i,
  input  logic                pwm_run_i,
  input  logic                adc_run_i,
  input  logic [NUM_GPIO-1:0] gpio_chg_i,
  input  logic [NUM_GPIO-1:0] gpio_irq_en_i,
  input  logic [NUM_GPIO-1:0] gpio_is_in_i,
  input  logic [NUM_SUB-1:0]  sub_clk_req_i,
  output logic                hib_o,
  output logic [NUM_SUB-1:0]  sub_clk_en_o
);
  logic wake, hold, rst_evt, expired, reload;

  pwr_wake_qual #(.NUM_GPIO(NUM_GPIO)) u_qual (
    .addr_hit_i   (addr_hit_i),
    .pen_down_i   (pen_down_i),
    .touch_en_i   (touch_en_i),
    .pwm_run_i    (pwm_run_i),
    .adc_run_i    (adc_run_i),
    .soft_rst_i   (soft_rst_i),
    .ext_rst_i    (ext_rst_i),
    .gpio_chg_i   (gpio_chg_i),
    .gpio_irq_en_i(gpio_irq_en_i),
    .gpio_is_in_i (gpio_is_in_i),
    .wake_o       (wake),
    .hold_o       (hold),
    .rst_evt_o    (rst_evt)
  );

  pwr_idle_timer #(.IDLE_CYCLES(IDLE_CYCLES)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .reload_i (reload),
    .expired_o(expired)
  );

  pwr_state_fsm #(.NUM_SUB(NUM_SUB)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .wake_i   (wake),
    .hold_i   (hold),
    .rst_evt_i(rst_evt),
    .expired_i(expired),
    .clk_req_i(sub_clk_req_i),
    .reload_o (reload),
    .hib_o    (hib_o),
    .clk_en_o (sub_clk_en_o)
  );
endmodule

// File: rtl/pwr_autohib_chk.sv
module pwr_autohib_chk #(
  parameter int NUM_GPIO    = 4,
  parameter int NUM_SUB     = 4,
  parameter int IDLE_CYCLES = 1650
) (
  input logic                clk,
  input logic                rst_n,
  input logic                soft_rst_i,
  input logic                ext_rst_i,
  input logic                addr_hit_i,
  input logic                pen_down_i,
  input logic                touch_en_i,
  input logic                pwm_run_i,
  input logic                adc_run_i,
  input logic [NUM_GPIO-1:0] gpio_chg_i,
  input logic [NUM_GPIO-1:0] gpio_irq_en_i,
  input logic [NUM_GPIO-1:0] gpio_is_in_i,
  input logic [NUM_SUB-1:0]  sub_clk_req_i,
  input logic                hib_o,
  input logic [NUM_SUB-1:0]  sub_clk_en_o
);
  localparam int IW = $clog2(IDLE_CYCLES + 2) + 1;

  logic          any_evt, keep_awake;
  logic [IW-1:0] quiet_q;

  assign keep_awake = pwm_run_i | adc_run_i | (pen_down_i & touch_en_i);
  assign any_evt = keep_awake | addr_hit_i | soft_rst_i | ext_rst_i |
                   (|(gpio_chg_i & gpio_irq_en_i & gpio_is_in_i));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        quiet_q <= '0;
    else if (any_evt)                  quiet_q <= '0;
    else if (quiet_q != {IW{1'b1}})    quiet_q <= quiet_q + 1'b1;
  end

  assert_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hib_o) |-> (quiet_q >= IW'(IDLE_CYCLES)));

  assert_hold_awake_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!hib_o && keep_awake) |=> !hib_o);

  assert_wake_next_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hib_o && any_evt) |=> !hib_o);

  assert_reset_active_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_rst_i || ext_rst_i) |=> !hib_o);

  assert_gated_clk_R10: assert property (@(posedge clk) disable iff (!rst_n)
    hib_o |-> (sub_clk_en_o == '0));

  assert_stay_asleep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hib_o && !any_evt) |=> hib_o);
endmodule

bind pwr_autohib pwr_autohib_chk #(
  .NUM_GPIO(NUM_GPIO), .NUM_SUB(NUM_SUB), .IDLE_CYCLES(IDLE_CYCLES)
) u_chk (.*);

// File: tb/sim_pwr_autohib.sv
`timescale 1ns/1ps
module sim_pwr_autohib;
  localparam int NG = 4;
  localparam int NS = 4;
  localparam int W  = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic soft_rst_i = 0, ext_rst_i = 0, addr_hit_i = 0, pen_down_i = 0;
  logic touch_en_i = 0, pwm_run_i = 0, adc_run_i = 0;
  logic [NG-1:0] gpio_chg_i = '0, gpio_irq_en_i = '0, gpio_is_in_i = '0;
  logic [NS-1:0] sub_clk_req_i = '0;
  logic          hib_o;
  logic [NS-1:0] sub_clk_en_o;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  pwr_autohib #(.NUM_GPIO(NG), .NUM_SUB(NS), .IDLE_CYCLES(W)) u0 (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle_to_sleep();
    repeat (W + 2) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 hib after reset", 32'(hib_o), 0);
    check("R1 clk_en after reset", 32'(sub_clk_en_o), 0);
    sub_clk_req_i = 4'b1011;
    @(negedge clk);
    check("R10 clk_en follows request", 32'(sub_clk_en_o), 32'hB);
  endtask

  task automatic t_entry();
    addr_hit_i = 1; @(negedge clk); addr_hit_i = 0;
    repeat (W) @(negedge clk);
    check("R2 still active at window end", 32'(hib_o), 0);
    @(negedge clk);
    check("R2 hibernate one edge later", 32'(hib_o), 1);
    check("R10 clk_en gated in hibernate", 32'(sub_clk_en_o), 0);
  endtask

  task automatic t_addr_wake();
    addr_hit_i = 1; @(negedge clk); addr_hit_i = 0;
    check("R7 R9 address match wakes next edge", 32'(hib_o), 0);
    check("R10 clk_en restored on wake", 32'(sub_clk_en_o), 32'hB);
  endtask

  task automatic t_reload();
    repeat (W / 2) @(negedge clk);
    gpio_chg_i = 4'b0100; gpio_irq_en_i = 4'b0100; gpio_is_in_i = 4'b0100;
    @(negedge clk); gpio_chg_i = '0;
    repeat (W) @(negedge clk);
    check("R3 window reloaded by activity", 32'(hib_o), 0);
    @(negedge clk);
    check("R3 hibernate after reloaded window", 32'(hib_o), 1);
  endtask

  task automatic t_hold();
    soft_rst_i = 1; @(negedge clk); soft_rst_i = 0;
    check("R8 soft reset wakes", 32'(hib_o), 0);
    pwm_run_i = 1;
    repeat (3 * W) @(negedge clk);
    check("R4 pwm running holds active", 32'(hib_o), 0);
    pwm_run_i = 0; adc_run_i = 1;
    repeat (3 * W) @(negedge clk);
    check("R4 adc running holds active", 32'(hib_o), 0);
    adc_run_i = 0;
    repeat (W) @(negedge clk);
    check("R4 active until window after adc stops", 32'(hib_o), 0);
    @(negedge clk);
    check("R4 hibernate after adc stops", 32'(hib_o), 1);
  endtask

  task automatic t_pen();
    touch_en_i = 0; pen_down_i = 1;
    repeat (5) @(negedge clk);
    check("R5 pen ignored when touch disabled", 32'(hib_o), 1);
    touch_en_i = 1; @(negedge clk);
    check("R5 R9 pen wakes when touch enabled", 32'(hib_o), 0);
    repeat (3 * W) @(negedge clk);
    check("R5 held pen keeps active", 32'(hib_o), 0);
    pen_down_i = 0; touch_en_i = 0;
    idle_to_sleep();
    check("R2 back to hibernate after pen", 32'(hib_o), 1);
  endtask

  task automatic t_gpio();
    gpio_chg_i = 4'b0010; gpio_irq_en_i = 4'b0000; gpio_is_in_i = 4'b0010;
    @(negedge clk);
    check("R6 change with irq disabled ignored", 32'(hib_o), 1);
    gpio_irq_en_i = 4'b0010; gpio_is_in_i = 4'b0000;
    @(negedge clk);
    check("R6 change on output pin ignored", 32'(hib_o), 1);
    gpio_is_in_i = 4'b0010;
    @(negedge clk);
    gpio_chg_i = '0;
    check("R6 R9 enabled input change wakes", 32'(hib_o), 0);
    idle_to_sleep();
  endtask

  task automatic t_ext_reset();
    check("R8 asleep before reset pin", 32'(hib_o), 1);
    ext_rst_i = 1; @(negedge clk); ext_rst_i = 0;
    check("R8 reset pin wakes", 32'(hib_o), 0);
    repeat (W) @(negedge clk);
    check("R8 full window after reset pin", 32'(hib_o), 0);
    @(negedge clk);
    check("R8 hibernate after window", 32'(hib_o), 1);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_entry();
        t_addr_wake();
        t_reload();
        t_hold();
        t_pen();
        t_gpio();
        t_ext_reset();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule